// File: doc/BRIEF.md
# Serial EEPROM Image Checker and Checksum Fixer

This block sits above a word-wide port into a small serial EEPROM and handles whole-image tasks. A check command reads all 64 words into a local shadow copy and keeps a 16-bit running sum. The image is accepted only if that sum matches a fixed target and the head word carries the expected signature. A fix command sums the first 63 words and writes the word that brings the total back to the target. A store command writes one word through to the EEPROM.

Lookups are served from the shadow copy. When the copy is known good, a lookup answers in one cycle without touching the EEPROM. Otherwise a full check runs first. A lookup returns zero when the index is out of range or the image is bad. Any write that goes out on the word port marks the copy as stale.

Commands are taken only when `busy` is low. Each command ends with a one-cycle `done` pulse, which carries a pass/fail flag and, for lookups, the data word.

Top module: `eeck_top`

## Requirements
- R1: After reset, `img_valid`, `busy`, `done` and `wp_req` are all low.
- R2: A check command (`cmd_op`=0) reads addresses 0 to 63 in ascending order. It passes (`done_ok`=1, `img_valid`=1) when the sum of all 64 words, wrapped to 16 bits, equals 0xBABA and head word 0 has bits [15:14] equal to 2'b01.
- R3: If a check finds a sum other than 0xBABA, the command fails. The signature bits [15:14] of the cached word 0 are cleared, so `img_valid` stays low and the next lookup rereads the EEPROM.
- R4: If a check finds a correct sum but word 0 bits [15:14] differ from 2'b01, the command fails and `img_valid` stays low.
- R5: A fix command (`cmd_op`=1) reads words 0 to 62 and then writes (0xBABA minus their 16-bit sum) mod 2^16 to word 63. It ends with `done_ok`=1.
- R6: Any write on the word port, whether acknowledged or errored, drives `img_valid` low.
- R7: A lookup (`cmd_op`=2) with index below 64 while `img_valid` is high returns the cached word with `done_ok`=1 on the next cycle. It makes no port request.
- R8: A lookup while `img_valid` is low first runs a full check. It then returns the word with `done_ok`=1 if the image passed, or 0 with `done_ok`=0 if it failed.
- R9: A lookup with `cmd_idx` of 64 or more returns 0 with `done_ok`=0 and makes no port request.
- R10: `wp_err` during a check or lookup reload aborts the command with `done_ok`=0 and leaves `img_valid` low.
- R11: Once raised, `wp_req` stays high with `wp_addr`, `wp_we` and `wp_wdata` held until `wp_ack` or `wp_err`.
- R12: A store command (`cmd_op`=3) writes `cmd_wdata` at `cmd_idx`. If `cmd_idx` is 64 or more, it is rejected with `done_ok`=0, makes no port request, and leaves `img_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 check, 1 fix, 2 lookup, 3 store |
| cmd_idx | input | 7 | Word index for lookup and store |
| cmd_wdata | input | 16 | Data word for store |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Pass flag, valid with done |
| rd_data | output | 16 | Lookup result, valid with done |
| img_valid | output | 1 | Shadow image currently trusted |
| wp_req | output | 1 | Word port request |
| wp_we | output | 1 | Word port write (1) or read (0) |
| wp_addr | output | 6 | Word port address |
| wp_wdata | output | 16 | Word port write data |
| wp_ack | input | 1 | Word port completion pulse |
| wp_err | input | 1 | Word port error pulse |
| wp_rdata | input | 16 | Word port read data, valid with wp_ack |

## Verification
Some rules are checked by assertions on every cycle:
- the request hold on the word port;
- that a failing completion carries zero data;
- the one-cycle answer on a cache hit;
- the rejection of out-of-range indexes;
- that a write or an aborted reload leaves the image untrusted;
- that a cleared signature really drops the head word's signature.

Other behaviours can only be shown by the directed scenarios against a bench memory model. These are the arithmetic of the sum and the correcting word, the ascending read order, the exact number of port transfers, and whether data from a stale cache is reread.

// File: rtl/eeck_pkg.sv
package eeck_pkg;
  typedef logic [15:0] word_t;

  localparam word_t SUM_TARGET = 16'hBABA;
  localparam word_t SIG_MASK   = 16'hC000;
  localparam word_t SIG_GOOD   = 16'h4000;

  typedef enum logic [1:0] {
    OP_CHECK = 2'd0,
    OP_FIX   = 2'd1,
    OP_FETCH = 2'd2,
    OP_STORE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2,
    S_EVAL  = 2'd3
  } state_e;

  // 16-bit wrapping accumulate
  function automatic word_t word_add(input word_t a, input word_t b);
    return word_t'(a + b);
  endfunction

  // value for the last word so the whole image sums to the target
  function automatic word_t fix_value(input word_t partial);
    return word_t'(SUM_TARGET - partial);
  endfunction

  function automatic logic sig_good(input word_t w);
    return (w & SIG_MASK) == SIG_GOOD;
  endfunction

  function automatic word_t sig_strip(input word_t w);
    return w & ~SIG_MASK;
  endfunction
endpackage

// File: rtl/eeck_shadow.sv
module eeck_shadow
  import eeck_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              clr_sig,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_word,
  output word_t             head_word
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
      // stripping the head signature wins over a same-cycle load of word 0
      if (clr_sig) mem_q[0] <= sig_strip((wr_en && wr_addr == '0) ? wr_data : mem_q[0]);
    end
  end

  assign rd_word   = mem_q[rd_addr];
  assign head_word = mem_q[0];

  p_sig_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sig |=> !sig_good(head_word));
endmodule

// File: rtl/eeck_port.sv
module eeck_port
  import eeck_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss,
  input  logic              iss_we,
  input  logic [ADDR_W-1:0] iss_addr,
  input  word_t             iss_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output word_t             rsp_data,
  output logic              wp_req,
  output logic              wp_we,
  output logic [ADDR_W-1:0] wp_addr,
  output word_t             wp_wdata,
  input  logic              wp_ack,
  input  logic              wp_err,
  input  word_t             wp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_req   <= 1'b0;
      wp_we    <= 1'b0;
      wp_addr  <= '0;
      wp_wdata <= '0;
    end else if (iss) begin
      wp_req   <= 1'b1;
      wp_we    <= iss_we;
      wp_addr  <= iss_addr;
      wp_wdata <= iss_wdata;
    end else if (wp_req && (wp_ack || wp_err)) begin
      wp_req <= 1'b0;
    end
  end

  assign rsp_ack  = wp_req && wp_ack;
  assign rsp_err  = wp_req && wp_err && !wp_ack;
  assign rsp_data = wp_rdata;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_req && !wp_ack && !wp_err) |=>
      (wp_req && $stable(wp_addr) && $stable(wp_we) && $stable(wp_wdata)));

  p_issue_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    iss |-> !wp_req);
endmodule

// File: rtl/eeck_seq.sv
module eeck_seq
  import eeck_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W:0]   cmd_idx,
  input  word_t             cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_ok,
  output word_t             rd_data,
  output logic              img_valid,
  output logic              iss,
  output logic              iss_we,
  output logic [ADDR_W-1:0] iss_addr,
  output word_t             iss_wdata,
  input  logic              rsp_ack,
  input  logic              rsp_err,
  input  word_t             rsp_data,
  output logic              sh_we,
  output logic [ADDR_W-1:0] sh_addr,
  output word_t             sh_data,
  output logic              sh_clr,
  output logic [ADDR_W-1:0] sh_rd_addr,
  input  word_t             sh_rd_word,
  input  word_t             sh_head
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ALL  = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] LAST_BODY = ADDR_W'(DEPTH - 2);

  state_e            st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] cnt_q, key_q, waddr_q;
  word_t             sum_q, wdata_q, rdat_q;
  logic              pend_q, loading_q, done_q, ok_q;

  op_e   cmd_kind;
  logic  idx_oor, last_word, fills_cache, sum_bad;
  word_t sum_nx;

  assign cmd_kind    = op_e'(cmd_op);
  assign idx_oor     = cmd_idx[ADDR_W];
  assign fills_cache = (op_q != OP_FIX);
  assign last_word   = (op_q == OP_FIX) ? (cnt_q == LAST_BODY) : (cnt_q == LAST_ALL);
  assign sum_nx      = word_add(sum_q, rsp_data);
  assign sum_bad     = (sum_nx != SUM_TARGET);
  assign img_valid   = sig_good(sh_head) && !loading_q;
  assign sh_rd_addr  = (st_q == S_IDLE) ? cmd_idx[ADDR_W-1:0] : key_q;

  always_comb begin
    iss       = 1'b0;
    iss_we    = 1'b0;
    iss_addr  = cnt_q;
    iss_wdata = wdata_q;
    if (st_q == S_READ && !pend_q) iss = 1'b1;
    if (st_q == S_WRITE) begin
      iss      = !pend_q;
      iss_we   = 1'b1;
      iss_addr = waddr_q;
    end
  end

  assign sh_we   = (st_q == S_READ) && rsp_ack && fills_cache;
  assign sh_addr = cnt_q;
  assign sh_data = rsp_data;
  assign sh_clr  = ((st_q == S_READ) && fills_cache &&
                    (rsp_err || (rsp_ack && last_word && sum_bad))) ||
                   ((st_q == S_WRITE) && (rsp_ack || rsp_err));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      op_q      <= OP_CHECK;
      cnt_q     <= '0;
      key_q     <= '0;
      waddr_q   <= '0;
      sum_q     <= '0;
      wdata_q   <= '0;
      rdat_q    <= '0;
      pend_q    <= 1'b0;
      loading_q <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_kind;
          key_q  <= cmd_idx[ADDR_W-1:0];
          cnt_q  <= '0;
          sum_q  <= '0;
          pend_q <= 1'b0;
          unique case (cmd_kind)
            OP_CHECK: begin
              st_q      <= S_READ;
              loading_q <= 1'b1;
            end
            OP_FIX: st_q <= S_READ;
            OP_FETCH: begin
              if (idx_oor) begin
                done_q <= 1'b1; ok_q <= 1'b0; rdat_q <= '0;
              end else if (img_valid) begin
                done_q <= 1'b1; ok_q <= 1'b1; rdat_q <= sh_rd_word;
              end else begin
                st_q      <= S_READ;
                loading_q <= 1'b1;
              end
            end
            OP_STORE: begin
              if (idx_oor) begin
                done_q <= 1'b1; ok_q <= 1'b0; rdat_q <= '0;
              end else begin
                waddr_q <= cmd_idx[ADDR_W-1:0];
                wdata_q <= cmd_wdata;
                st_q    <= S_WRITE;
              end
            end
          endcase
        end
        S_READ: begin
          if (iss) pend_q <= 1'b1;
          if (rsp_ack) begin
            pend_q <= 1'b0;
            sum_q  <= sum_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (last_word) begin
              if (op_q == OP_FIX) begin
                st_q    <= S_WRITE;
                waddr_q <= LAST_ALL;
                wdata_q <= fix_value(sum_nx);
              end else begin
                loading_q <= 1'b0;
                st_q      <= S_EVAL;
              end
            end
          end else if (rsp_err) begin
            pend_q    <= 1'b0;
            loading_q <= 1'b0;
            done_q    <= 1'b1;
            ok_q      <= 1'b0;
            rdat_q    <= '0;
            st_q      <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (iss) pend_q <= 1'b1;
          if (rsp_ack || rsp_err) begin
            pend_q <= 1'b0;
            done_q <= 1'b1;
            ok_q   <= rsp_ack;
            rdat_q <= '0;
            st_q   <= S_IDLE;
          end
        end
        S_EVAL: begin
          done_q <= 1'b1;
          ok_q   <= img_valid;
          rdat_q <= (op_q == OP_FETCH && img_valid) ? sh_rd_word : '0;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign done_ok = ok_q;
  assign rd_data = rdat_q;

  p_fail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |-> (rd_data == '0));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hit_quick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_kind == OP_FETCH && !idx_oor && img_valid)
      |=> (done && done_ok && !busy && !pend_q));

  p_oor_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && idx_oor && (cmd_kind == OP_FETCH || cmd_kind == OP_STORE))
      |=> (done && !done_ok && !busy));

  p_write_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_WRITE) && (rsp_ack || rsp_err)) |=> !img_valid);

  p_abort_stale_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_READ) && rsp_err && fills_cache) |=> (!img_valid && !busy));
endmodule

// File: rtl/eeck_top.sv
module eeck_top
  import eeck_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W:0]   cmd_idx,
  input  logic [15:0]       cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_ok,
  output logic [15:0]       rd_data,
  output logic              img_valid,
  output logic              wp_req,
  output logic              wp_we,
  output logic [ADDR_W-1:0] wp_addr,
  output logic [15:0]       wp_wdata,
  input  logic              wp_ack,
  input  logic              wp_err,
  input  logic [15:0]       wp_rdata
);
  logic              iss, iss_we, rsp_ack, rsp_err;
  logic [ADDR_W-1:0] iss_addr;
  word_t             iss_wdata, rsp_data;
  logic              sh_we, sh_clr;
  logic [ADDR_W-1:0] sh_addr, sh_rd_addr;
  word_t             sh_data, sh_rd_word, sh_head;

  eeck_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .done_ok(done_ok), .rd_data(rd_data), .img_valid(img_valid),
    .iss(iss), .iss_we(iss_we), .iss_addr(iss_addr), .iss_wdata(iss_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .sh_we(sh_we), .sh_addr(sh_addr), .sh_data(sh_data), .sh_clr(sh_clr),
    .sh_rd_addr(sh_rd_addr), .sh_rd_word(sh_rd_word), .sh_head(sh_head)
  );

  eeck_port #(.ADDR_W(ADDR_W)) port_i (
    .clk(clk), .rst_n(rst_n),
    .iss(iss), .iss_we(iss_we), .iss_addr(iss_addr), .iss_wdata(iss_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .wp_req(wp_req), .wp_we(wp_we), .wp_addr(wp_addr), .wp_wdata(wp_wdata),
    .wp_ack(wp_ack), .wp_err(wp_err), .wp_rdata(wp_rdata)
  );

  eeck_shadow #(.ADDR_W(ADDR_W)) shadow_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sh_we), .wr_addr(sh_addr), .wr_data(sh_data), .clr_sig(sh_clr),
    .rd_addr(sh_rd_addr), .rd_word(sh_rd_word), .head_word(sh_head)
  );
endmodule

// File: tb/eeck_top_tb_top.sv
module eeck_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [6:0]  cmd_idx = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, done_ok, img_valid;
  logic [15:0] rd_data;
  logic        wp_req, wp_we;
  logic [5:0]  wp_addr;
  logic [15:0] wp_wdata;
  logic        wp_ack = 1'b0, wp_err = 1'b0;
  logic [15:0] wp_rdata = '0;

  always #2 clk = ~clk;

  eeck_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .done_ok(done_ok), .rd_data(rd_data), .img_valid(img_valid),
    .wp_req(wp_req), .wp_we(wp_we), .wp_addr(wp_addr), .wp_wdata(wp_wdata),
    .wp_ack(wp_ack), .wp_err(wp_err), .wp_rdata(wp_rdata)
  );

  int total = 0, bad = 0;
  logic [15:0] mem [64];
  int  nrd = 0, nwr = 0, lat = 1, wcnt = 0;
  logic err_on = 1'b0;
  logic [5:0] err_addr = '0, exp_addr = '0, paddr = '0;
  logic preq = 1'b0, pwe = 1'b0, order_bad = 1'b0, hold_bad = 1'b0;
  logic r_ok;
  logic [15:0] r_rd;

  // memory model on the word port
  always @(posedge clk) begin
    wp_ack <= 1'b0;
    wp_err <= 1'b0;
    if (wp_req && preq && !wp_ack && !wp_err && (wp_addr != paddr || wp_we != pwe))
      hold_bad <= 1'b1;
    preq  <= wp_req;
    paddr <= wp_addr;
    pwe   <= wp_we;
    if (rst_n && wp_req && !wp_ack && !wp_err) begin
      if (wcnt >= lat) begin
        wcnt <= 0;
        if (err_on && wp_addr == err_addr) wp_err <= 1'b1;
        else begin
          wp_ack <= 1'b1;
          if (wp_we) begin
            mem[wp_addr] <= wp_wdata;
            nwr <= nwr + 1;
          end else begin
            wp_rdata <= mem[wp_addr];
            nrd <= nrd + 1;
            if (wp_addr != exp_addr) order_bad <= 1'b1;
            exp_addr <= wp_addr + 6'd1;
          end
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [6:0] idx, input logic [15:0] wd);
    nrd = 0; nwr = 0; exp_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    r_ok = done_ok;
    r_rd = rd_data;
    @(negedge clk);
  endtask

  // build an image whose full sum hits the target
  task automatic fill_image(input logic [15:0] seed, input logic [15:0] head);
    logic [15:0] acc;
    mem[0] = head;
    acc = head;
    for (int i = 1; i < 63; i++) begin
      mem[i] = (seed * i[15:0]) ^ 16'h1357 ^ {i[7:0], 8'h00};
      acc = acc + mem[i];
    end
    mem[63] = 16'hBABA - acc;
  endtask

  function automatic logic [15:0] body_sum();
    logic [15:0] acc = '0;
    for (int i = 0; i < 63; i++) acc = acc + mem[i];
    return acc;
  endfunction

  task automatic t_reset();
    check("R1 img_valid", img_valid, 0);
    check("R1 busy", busy, 0);
    check("R1 wp_req", wp_req, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_validate_good(input logic [15:0] seed, input int l);
    lat = l;
    fill_image(seed, 16'h4A21);
    order_bad = 1'b0;
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R2 ok", r_ok, 1);
    check("R2 img_valid", img_valid, 1);
    check("R2 reads", nrd, 64);
    check("R2 order", order_bad, 0);
  endtask

  task automatic t_lookup_hit();
    run_cmd(2'd2, 7'd5, 16'd0);
    check("R7 data", r_rd, mem[5]);
    check("R7 ok", r_ok, 1);
    check("R7 no traffic", nrd + nwr, 0);
    run_cmd(2'd2, 7'd63, 16'd0);
    check("R7 data last", r_rd, mem[63]);
  endtask

  task automatic t_range();
    run_cmd(2'd2, 7'd64, 16'd0);
    check("R9 data", r_rd, 0);
    check("R9 ok", r_ok, 0);
    run_cmd(2'd2, 7'd100, 16'd0);
    check("R9 data hi", r_rd, 0);
    check("R9 no traffic", nrd + nwr, 0);
    run_cmd(2'd3, 7'd70, 16'h1111);
    check("R12 ok", r_ok, 0);
    check("R12 no write", nwr, 0);
    check("R12 img_valid kept", img_valid, 1);
  endtask

  task automatic t_update();
    logic [15:0] expw;
    mem[10] = mem[10] ^ 16'h00FF;
    expw = 16'hBABA - body_sum();
    run_cmd(2'd1, 7'd0, 16'd0);
    check("R5 ok", r_ok, 1);
    check("R5 word63", mem[63], expw);
    check("R5 reads", nrd, 63);
    check("R5 writes", nwr, 1);
    check("R6 after fix", img_valid, 0);
    run_cmd(2'd2, 7'd10, 16'd0);
    check("R8 reload reads", nrd, 64);
    check("R8 data", r_rd, mem[10]);
    check("R8 ok", r_ok, 1);
  endtask

  task automatic t_write_then_bad();
    logic [15:0] nv;
    nv = mem[3] ^ 16'h0F0F;
    run_cmd(2'd3, 7'd3, nv);
    check("R12 store ok", r_ok, 1);
    check("R12 stored", mem[3], nv);
    check("R6 after store", img_valid, 0);
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R3 ok", r_ok, 0);
    check("R3 img_valid", img_valid, 0);
    run_cmd(2'd2, 7'd3, 16'd0);
    check("R3 reread", nrd, 64);
    check("R8 bad data", r_rd, 0);
    check("R8 bad ok", r_ok, 0);
  endtask

  task automatic t_signature();
    fill_image(16'h2B7D, 16'hC123);
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R4 ok", r_ok, 0);
    check("R4 img_valid", img_valid, 0);
    fill_image(16'h2B7D, 16'h0123);
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R4 ok zero sig", r_ok, 0);
  endtask

  task automatic t_error();
    fill_image(16'h0815, 16'h4001);
    err_on = 1'b1; err_addr = 6'd20;
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R10 ok", r_ok, 0);
    check("R10 img_valid", img_valid, 0);
    check("R10 acked reads", nrd, 20);
    err_on = 1'b0;
    run_cmd(2'd0, 7'd0, 16'd0);
    check("R10 recover", r_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_validate_good(16'h3A5C, 1);
    t_lookup_hit();
    t_range();
    t_update();
    t_write_then_bad();
    t_signature();
    t_error();
    t_validate_good(16'h9E11, 0);
    t_validate_good(16'h7777, 3);
    check("R11 hold", hold_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule